// File: doc/BRIEF.md
# ADC conversion sequence controller

This block sequences conversions for an analog-to-digital converter over a list of eight slots. Each slot holds a 4-bit channel number. Software programs the slot list, a conversion length in clocks, an operating mode and a start bit. The controller then steps through the slots. For each conversion it drives the channel number to the converter, issues a one-cycle start pulse and counts the programmed number of conversion clocks. At the end of each conversion it pulses a write strobe for the slot that just completed.

Three modes are available. Single mode converts slot 0 once. Single-pass scan mode converts slots 0 to 7 once, in order. Continuous mode repeats the scan until software clears the start bit. In the first two modes the controller clears the start bit itself when it finishes. A down-sample enable forces continuous operation whatever the mode field holds. An end-of-conversion flag marks each finished operation; writing 1 clears it, and it drives an interrupt through an enable.

The result write strobe only announces that a result is ready. It has no ready input and there is no back-pressure, so the result store must take the value in the cycle the strobe is high. All other pins are plain control and status levels.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, conv_start, slot_wr, busy, cur_slot, eoc_flag and irq are all 0.
- R2: One clock after the start bit becomes 1 with adc_en at 1, conv_start pulses for one cycle. For a conversion of slot s, chan_sel equals seq_word[4s+3:4s], so slot 0 uses bits 3:0 and slot 7 uses bits 31:28.
- R3: A conversion lasts N clocks, where N is conv_clks when conv_clks is 11 or more, and 11 otherwise. slot_wr is high N-1 cycles after the conv_start cycle and stays high for one cycle. In that cycle only bit s of slot_wr is set, and cur_slot equals s.
- R4: Single mode (mode_sel 00) converts slot 0 once. The reserved code 01 behaves the same way. After the write strobe the start bit, and so busy, returns to 0 and no further conversion starts.
- R5: Single-pass scan mode (mode_sel 10) converts slots 0 to 7 in order, back to back. Each new conv_start comes in the cycle after the previous write strobe. After slot 7 the start bit returns to 0.
- R6: Continuous mode (mode_sel 11) goes from slot 7 back to slot 0 and continues. The start bit stays at 1.
- R7: With ds_force at 1 the controller runs continuous scan, whatever the value of mode_sel.
- R8: eoc_flag is set in the cycle after the write strobe that ends a pass: slot 0 in single mode, slot 7 in scan modes. A pulse on eoc_clr clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: irq is 1 exactly when irq_en is 1 and eoc_flag is 1.
- R10: While adc_en is 0 the controller stays idle. No conv_start or slot_wr is issued, even with the start bit set.
- R11: If software writes 0 to the start bit during a conversion, the conversion is aborted. No slot_wr is issued for it, and the controller returns to idle.
- R12: busy mirrors the start bit. After a start_we pulse, busy equals the written start_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_en | input | 1 | Converter enable |
| mode_sel | input | 2 | Mode: 00 single, 01 reserved (acts as single), 10 single-pass scan, 11 continuous |
| start_we | input | 1 | Write strobe for the start bit |
| start_wdata | input | 1 | Value written to the start bit |
| ds_force | input | 1 | Down-sample enable; forces continuous scan |
| seq_word | input | 32 | Eight 4-bit channel fields, slot s at bits 4s+3:4s |
| conv_clks | input | 7 | Clocks per conversion (floor of 11) |
| irq_en | input | 1 | Interrupt enable |
| eoc_clr | input | 1 | Write-one pulse that clears eoc_flag |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| chan_sel | output | 4 | Channel of the current slot |
| slot_wr | output | 8 | One-hot result write strobe, one bit per slot |
| busy | output | 1 | Mirror of the start bit |
| cur_slot | output | 3 | Current slot number |
| eoc_flag | output | 1 | End-of-conversion flag |
| irq | output | 1 | Interrupt request |

## Verification
A start write is seen on busy one clock after the write edge. conv_start follows one clock later. slot_wr comes N-1 cycles after conv_start, and in scan modes the next conv_start comes in the following cycle. After a pass-ending strobe, eoc_flag rises and, in single or scan mode, busy falls one clock later. The bench drives inputs and samples outputs on falling edges. It counts falling edges from each observed conv_start up to the strobe and compares the count with N-1, where N is the clamped length it computes itself. Flag and busy checks are sampled exactly one falling edge after the pass-ending strobe. Abort and disabled cases are watched over a window of 40 cycles, which is longer than any conversion used there.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_SCAN   = 2'b10,
    MODE_CONT   = 2'b11
  } seq_mode_e;

  // Requested clock count raised to the legal floor.
  function automatic int unsigned clamp_clks(int unsigned req, int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W    = 7,
  parameter int MIN_CLKS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] conv_clks,
  output logic             first,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim   = CNT_W'(adc_seq_pkg::clamp_clks(32'(conv_clks), MIN_CLKS));
    first = run && (cnt_q == '0);
    last  = run && (cnt_q == lim - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run || last) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/adc_seq_slots.sv
module adc_seq_slots #(
  parameter int SLOTS = 8,
  parameter int CH_W  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int SEQ_W  = SLOTS * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_zero,
  input  logic              step,
  input  logic              wrap,
  input  logic              strobe,
  input  logic [SEQ_W-1:0]  seq_word,
  output logic [SLOT_W-1:0] slot,
  output logic              at_last,
  output logic [CH_W-1:0]   chan,
  output logic [SLOTS-1:0]  wr
);

  logic [CH_W-1:0] field [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign field[g] = seq_word[g*CH_W +: CH_W];
    assign wr[g]    = strobe && (slot == SLOT_W'(g));
  end

  assign chan    = field[slot];
  assign at_last = (slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       slot <= '0;
    else if (hold_zero || (step && wrap)) slot <= '0;
    else if (step)                    slot <= slot + 1'b1;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int SLOTS    = 8,
  parameter int CH_W     = 4,
  parameter int CNT_W    = 7,
  parameter int MIN_CLKS = 11,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int SEQ_W   = SLOTS * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_en,
  input  logic [1:0]        mode_sel,
  input  logic              start_we,
  input  logic              start_wdata,
  input  logic              ds_force,
  input  logic [SEQ_W-1:0]  seq_word,
  input  logic [CNT_W-1:0]  conv_clks,
  input  logic              irq_en,
  input  logic              eoc_clr,
  output logic              conv_start,
  output logic [CH_W-1:0]   chan_sel,
  output logic [SLOTS-1:0]  slot_wr,
  output logic              busy,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              eoc_flag,
  output logic              irq
);

  import adc_seq_pkg::*;

  seq_mode_e eff_mode;
  logic one_shot, cont;
  logic start_q, active_q, eoc_q;
  logic go, run, done, at_last, pass_end;

  assign eff_mode = ds_force ? MODE_CONT : seq_mode_e'(mode_sel);
  assign one_shot = (eff_mode == MODE_SINGLE) || (eff_mode == MODE_RSVD);
  assign cont     = (eff_mode == MODE_CONT);

  assign go       = adc_en && start_q;
  assign run      = go && active_q;
  assign pass_end = done && (one_shot || at_last);

  adc_seq_timer #(.CNT_W(CNT_W), .MIN_CLKS(MIN_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .conv_clks (conv_clks),
    .first     (conv_start),
    .last      (done)
  );

  adc_seq_slots #(.SLOTS(SLOTS), .CH_W(CH_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_zero (!active_q),
    .step      (done),
    .wrap      (one_shot || at_last),
    .strobe    (done),
    .seq_word  (seq_word),
    .slot      (cur_slot),
    .at_last   (at_last),
    .chan      (chan_sel),
    .wr        (slot_wr)
  );

  // Sequencer activity: leaves on abort/disable or at the end of a non-continuous pass.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 active_q <= 1'b0;
    else if (!go)               active_q <= 1'b0;
    else if (pass_end && !cont) active_q <= 1'b0;
    else                        active_q <= 1'b1;
  end

  // Start bit: a software write takes precedence over the hardware self-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 start_q <= 1'b0;
    else if (start_we)          start_q <= start_wdata;
    else if (pass_end && !cont) start_q <= 1'b0;
  end

  // End flag: set wins over a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        eoc_q <= 1'b0;
    else if (pass_end) eoc_q <= 1'b1;
    else if (eoc_clr)  eoc_q <= 1'b0;
  end

  assign busy     = start_q;
  assign eoc_flag = eoc_q;
  assign irq      = irq_en && eoc_q;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int SLOTS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_en,
  input logic [1:0]       mode_sel,
  input logic             start_we,
  input logic             start_wdata,
  input logic             ds_force,
  input logic             conv_start,
  input logic [SLOTS-1:0] slot_wr,
  input logic             busy,
  input logic             eoc_flag
);

  a_r3_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_wr));

  a_r3_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r4_single_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr != '0 && !ds_force && mode_sel == 2'b00 && !start_we) |=> !busy);

  a_r7_forced_cont_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr != '0 && ds_force && !start_we) |=> busy);

  a_r8_pass_sets_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr[SLOTS-1] |=> eoc_flag);

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |-> (slot_wr == '0 && !conv_start));

  a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (slot_wr == '0));

  a_r12_busy_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> (busy == $past(start_wdata)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SLOTS(SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adc_en      (adc_en),
  .mode_sel    (mode_sel),
  .start_we    (start_we),
  .start_wdata (start_wdata),
  .ds_force    (ds_force),
  .conv_start  (conv_start),
  .slot_wr     (slot_wr),
  .busy        (busy),
  .eoc_flag    (eoc_flag)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adc_en, start_we, start_wdata, ds_force, irq_en, eoc_clr;
  logic [1:0]  mode_sel;
  logic [31:0] seq_word;
  logic [6:0]  conv_clks;
  logic        conv_start, busy, eoc_flag, irq;
  logic [3:0]  chan_sel;
  logic [7:0]  slot_wr;
  logic [2:0]  cur_slot;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .mode_sel(mode_sel),
    .start_we(start_we), .start_wdata(start_wdata), .ds_force(ds_force),
    .seq_word(seq_word), .conv_clks(conv_clks), .irq_en(irq_en), .eoc_clr(eoc_clr),
    .conv_start(conv_start), .chan_sel(chan_sel), .slot_wr(slot_wr), .busy(busy),
    .cur_slot(cur_slot), .eoc_flag(eoc_flag), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int len_exp(input int c);
    return (c < 11) ? 11 : c;
  endfunction

  function automatic int field_exp(input logic [31:0] w, input int s);
    return int'((w >> (4*s)) & 32'hF);
  endfunction

  task automatic wr_start(input bit v);
    @(negedge clk); start_we = 1'b1; start_wdata = v;
    @(negedge clk); start_we = 1'b0;
  endtask

  task automatic clr_eoc();
    @(negedge clk); eoc_clr = 1'b1;
    @(negedge clk); eoc_clr = 1'b0;
  endtask

  // Waits for the start pulse of a slot, then for its strobe.
  task automatic do_conv(input int s, input string req);
    int k = 0;
    while (!conv_start && k < 300) begin @(negedge clk); k++; end
    chk(conv_start == 1'b1, "R2", "conv_start seen", int'(conv_start), 1);
    chk(int'(chan_sel) == field_exp(seq_word, s), "R2", "chan_sel", int'(chan_sel),
        field_exp(seq_word, s));
    k = 0;
    do begin @(negedge clk); k++; end while (slot_wr == '0 && k < 300);
    chk(k == len_exp(int'(conv_clks)) - 1, "R3", "start-to-strobe cycles", k,
        len_exp(int'(conv_clks)) - 1);
    chk(int'(slot_wr) == (1 << s), req, "slot_wr one-hot", int'(slot_wr), 1 << s);
    chk(int'(cur_slot) == s, req, "cur_slot", int'(cur_slot), s);
  endtask

  task automatic quiet_window(input string req);
    int seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (conv_start || slot_wr != '0) seen++;
    end
    chk(seen == 0, req, "activity in quiet window", seen, 0);
  endtask

  task automatic abort_mid();
    int k = 0;
    while (!conv_start && k < 300) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    wr_start(1'b0);
    quiet_window("R11");
    chk(busy == 1'b0, "R11", "busy after abort", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; adc_en = 1'b0; start_we = 1'b0; start_wdata = 1'b0;
    ds_force = 1'b0; irq_en = 1'b0; eoc_clr = 1'b0; mode_sel = 2'b00;
    seq_word = 32'h0; conv_clks = 7'd0;
    repeat (3) @(negedge clk);
    chk({conv_start, slot_wr, busy, cur_slot, eoc_flag, irq} == '0, "R1",
        "outputs in reset", int'(slot_wr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({conv_start, slot_wr, busy, cur_slot, eoc_flag, irq} == '0, "R1",
        "outputs after reset", int'(busy), 0);

    // Single mode, length below floor.
    adc_en = 1'b1; irq_en = 1'b1; seq_word = 32'h7654_32A5; conv_clks = 7'd5;
    wr_start(1'b1);
    chk(busy == 1'b1, "R12", "busy after start write", int'(busy), 1);
    do_conv(0, "R4");
    @(negedge clk);
    chk(busy == 1'b0, "R4", "busy after single", int'(busy), 0);
    chk(eoc_flag == 1'b1, "R8", "eoc after single", int'(eoc_flag), 1);
    chk(irq == 1'b1, "R9", "irq with enable", int'(irq), 1);
    quiet_window("R4");
    clr_eoc();
    chk(eoc_flag == 1'b0, "R8", "eoc after clear", int'(eoc_flag), 0);
    chk(irq == 1'b0, "R9", "irq after clear", int'(irq), 0);

    // Reserved code acts as single; set wins over a same-cycle clear.
    mode_sel = 2'b01; conv_clks = 7'd13; seq_word = 32'h0000_0009;
    wr_start(1'b1);
    do_conv(0, "R4");
    eoc_clr = 1'b1;
    @(negedge clk); eoc_clr = 1'b0;
    chk(eoc_flag == 1'b1, "R8", "set wins over clear", int'(eoc_flag), 1);
    chk(busy == 1'b0, "R4", "busy after reserved mode", int'(busy), 0);

    // Random single-pass scans.
    mode_sel = 2'b10;
    for (int it = 0; it < 5; it++) begin
      seq_word  = $urandom;
      conv_clks = 7'($urandom_range(0, 30));
      irq_en    = 1'($urandom_range(0, 1));
      clr_eoc();
      wr_start(1'b1);
      for (int s = 0; s < 8; s++) do_conv(s, "R5");
      @(negedge clk);
      chk(busy == 1'b0, "R5", "busy after scan pass", int'(busy), 0);
      chk(eoc_flag == 1'b1, "R8", "eoc after scan pass", int'(eoc_flag), 1);
      chk(irq == irq_en, "R9", "irq follows enable", int'(irq), int'(irq_en));
    end

    // Continuous scan with wrap, then abort.
    mode_sel = 2'b11; conv_clks = 7'd12; seq_word = 32'hFEDC_BA98;
    clr_eoc();
    wr_start(1'b1);
    for (int i = 0; i < 10; i++) do_conv(i % 8, "R6");
    chk(busy == 1'b1, "R6", "busy in continuous", int'(busy), 1);
    chk(eoc_flag == 1'b1, "R8", "eoc after first pass", int'(eoc_flag), 1);
    abort_mid();

    // Down-sample forces continuous over single.
    mode_sel = 2'b00; ds_force = 1'b1; conv_clks = 7'd11; seq_word = $urandom;
    wr_start(1'b1);
    for (int i = 0; i < 9; i++) do_conv(i % 8, "R7");
    chk(busy == 1'b1, "R7", "busy with forced continuous", int'(busy), 1);
    abort_mid();
    ds_force = 1'b0;

    // Disabled converter ignores start.
    adc_en = 1'b0;
    wr_start(1'b1);
    quiet_window("R10");
    chk(busy == 1'b1, "R12", "busy mirrors start while disabled", int'(busy), 1);
    wr_start(1'b0);
    adc_en = 1'b1;
    quiet_window("R10");
    chk(busy == 1'b0, "R12", "busy after clearing start", int'(busy), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule